// File: doc/BRIEF.md
# Contiguity-Coalescing Translation Buffer

This block is a small, fully associative translation buffer for 4KB pages. An external page table walker feeds it one 4KB translation per fill. The block watches for an aligned run of four consecutive virtual pages that land on four physically contiguous frames with the same attribute bits. Such a run is held in a single entry, and once all four pages are present that entry answers lookups as one 16KB page. The same number of entries therefore covers more address space when the operating system hands out contiguous frames.

A lookup presents a virtual address. One clock later the block returns hit or miss, the physical address and the attributes, plus a flag that says whether the hit came from a complete 16KB group. Replacement steps a round-robin pointer through the entries. A single global invalidate empties the whole buffer in one cycle.

Top module: `ctlb_top`

## Requirements
- R1: After reset, and in any response that misses, `rsp_hit` and `rsp_big` are both 0.
- R2: After a single 4KB fill (vpn V, frame P, attributes A), a lookup in page V hits with physical address {P, page offset} and attributes A, and `rsp_big` is 0. A lookup in any other page misses.
- R3: Four fills with vpn 4G+k mapped to frame 4F+k (k = 0..3, where the vpn's two low bits equal k) with equal attributes end up in one entry. A lookup in any of the four pages then returns {4F+k, offset} with `rsp_big` = 1. With fewer than four pages present, `rsp_big` stays 0.
- R4: A fill whose frame breaks contiguity with a partially built group is placed in an entry of its own. The group keeps its pages, and both translations read back correctly.
- R5: A fill whose attributes differ from those of a partial group is not merged into it. Each page returns its own attributes, and `rsp_big` stays 0.
- R6: A fill whose frame's two low bits differ from the vpn's two low bits (misaligned physically) is stored as a lone 4KB entry that never merges and never reports `rsp_big`.
- R7: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_valid` = 1. The response reflects the buffer contents before any fill or invalidate applied in the lookup's own cycle.
- R8: Every fill that creates a new entry writes the entry under the round-robin pointer and advances that pointer, wrapping after the last entry. Fills that merge into an existing group do not move the pointer. Once every entry is used, the next new entry evicts the oldest one.
- R9: `inv_all` clears every entry in one cycle, so all later lookups miss. It also returns the pointer to entry 0 and takes priority over a fill in the same cycle.
- R10: A fill for a page that is already mapped removes that page from its old entry, so at most one entry ever matches a lookup and the newest translation is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_big | output | 1 | Hit came from a complete 16KB group |
| rsp_paddr | output | PA_W | Physical address |
| rsp_attr | output | ATTR_W | Attribute bits of the hit |
| fill_valid | input | 1 | Install a 4KB translation |
| fill_vpn | input | VA_W-12 | Virtual page number of the fill |
| fill_ppn | input | PA_W-12 | Physical frame number of the fill |
| fill_attr | input | ATTR_W | Attribute bits of the fill |
| inv_all | input | 1 | Invalidate all entries |

## Verification
The bench fills a group one page at a time and checks that `rsp_big` rises only with the fourth page. A design that promoted a group early, or that compared the low vpn bits after promotion, would return the wrong frame or miss. It breaks groups by frame, by attributes and by physical misalignment, which catches a buffer that merges blindly and corrupts the group's frame. It re-maps an already covered page, which exposes a buffer that keeps a stale second copy. It also overfills the buffer to check that eviction hits the oldest entry rather than a merged group that was skipped.

// File: rtl/ctlb_pkg.sv
// Shared types for the coalescing translation buffer.
package ctlb_pkg;
    // What a fill does to the entry array.
    typedef enum logic [1:0] {
        FA_NONE  = 2'd0,
        FA_MERGE = 2'd1,
        FA_ALLOC = 2'd2
    } fill_act_e;

    localparam int unsigned GRP_PAGES = 4;
    localparam int unsigned GRP_BITS  = 2;
    localparam int unsigned PG_SHIFT  = 12;
endpackage

// File: rtl/ctlb_cmp.sv
// Per-entry comparator. It decides whether the entry matches the lookup page,
// whether it currently covers the fill page, and whether the fill can be merged
// into it. Assumes group entries keep frame low bits equal to vpn low bits.
module ctlb_cmp #(
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned PPN_W  = 20,
    parameter int unsigned ATTR_W = 4
) (
    input  logic              e_valid,
    input  logic [VPN_W-3:0]  e_vtag,
    input  logic [PPN_W-3:0]  e_ptag,
    input  logic [ATTR_W-1:0] e_attr,
    input  logic [3:0]        e_mask,
    input  logic              e_solo,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [VPN_W-1:0]  f_vpn,
    input  logic [PPN_W-1:0]  f_ppn,
    input  logic [ATTR_W-1:0] f_attr,
    output logic              lk_hit,
    output logic              f_cover,
    output logic              f_compat
);
    logic f_tag_eq;
    logic f_aligned;

    // Lookup match: same group tag and the addressed slot is present.
    always_comb lk_hit = e_valid && (e_vtag == lk_vpn[VPN_W-1:2]) && e_mask[lk_vpn[1:0]];

    // Fill-side matching: cover means the page is already mapped here.
    always_comb begin
        f_tag_eq  = e_valid && (e_vtag == f_vpn[VPN_W-1:2]);
        f_aligned = (f_ppn[1:0] == f_vpn[1:0]);
        f_cover   = f_tag_eq && e_mask[f_vpn[1:0]];
        f_compat  = f_tag_eq && !e_solo && f_aligned &&
                    (e_ptag == f_ppn[PPN_W-1:2]) && (e_attr == f_attr);
    end
endmodule

// File: rtl/ctlb_fill_ctl.sv
// Fill decision and round-robin victim pointer. It picks the lowest compatible
// entry for a merge, otherwise it allocates at the pointer. Assumes inv_all
// overrides any fill in the same cycle.
module ctlb_fill_ctl
    import ctlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_valid,
    input  logic               inv_all,
    input  logic [ENTRIES-1:0] compat,
    output fill_act_e          act,
    output logic [IDX_W-1:0]   tgt_idx,
    output logic [IDX_W-1:0]   ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // Choose the action and the lowest-index merge target.
    always_comb begin
        act     = FA_NONE;
        tgt_idx = '0;
        if (fill_valid && !inv_all) begin
            act = FA_ALLOC;
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (compat[i]) begin
                    act     = FA_MERGE;
                    tgt_idx = IDX_W'(i);
                end
            end
        end
    end

    // Advance the victim pointer on each allocation; invalidate rewinds it.
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            ptr <= '0;
        end else if (act == FA_ALLOC) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/ctlb_top.sv
// Coalescing translation buffer top. It holds ENTRIES group entries, each able
// to carry up to four 4KB pages of one 16KB-aligned virtual group mapped onto
// one 16KB-aligned frame group, or one misaligned lone page. It has a one-cycle
// registered lookup, merge-or-allocate fills and a one-cycle global invalidate.
module ctlb_top
    import ctlb_pkg::*;
#(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned PA_W    = 32,
    parameter int unsigned ATTR_W  = 4,
    parameter int unsigned ENTRIES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_valid,
    input  logic [VA_W-1:0]        lk_vaddr,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_big,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic [ATTR_W-1:0]      rsp_attr,
    input  logic                   fill_valid,
    input  logic [VA_W-13:0]       fill_vpn,
    input  logic [PA_W-13:0]       fill_ppn,
    input  logic [ATTR_W-1:0]      fill_attr,
    input  logic                   inv_all
);
    localparam int unsigned VPN_W  = VA_W - PG_SHIFT;
    localparam int unsigned PPN_W  = PA_W - PG_SHIFT;
    localparam int unsigned VTAG_W = VPN_W - GRP_BITS;
    localparam int unsigned PTAG_W = PPN_W - GRP_BITS;
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    // Entry storage.
    logic [ENTRIES-1:0]   ent_valid;
    logic [VTAG_W-1:0]    ent_vtag  [ENTRIES];
    logic [PTAG_W-1:0]    ent_ptag  [ENTRIES];
    logic [ATTR_W-1:0]    ent_attr  [ENTRIES];
    logic [3:0]           ent_mask  [ENTRIES];
    logic [ENTRIES-1:0]   ent_solo;
    logic [1:0]           ent_sololo[ENTRIES];

    logic [VPN_W-1:0]     lk_vpn;
    logic [ENTRIES-1:0]   lk_hit_vec;
    logic [ENTRIES-1:0]   f_cover_vec;
    logic [ENTRIES-1:0]   f_compat_vec;
    fill_act_e            act;
    logic [IDX_W-1:0]     tgt_idx;
    logic [IDX_W-1:0]     ptr;
    logic                 fill_alloc;
    logic [3:0]           f_slot;
    logic                 f_aligned;

    always_comb lk_vpn     = lk_vaddr[VA_W-1:PG_SHIFT];
    always_comb fill_alloc = (act == FA_ALLOC);
    always_comb f_slot     = 4'b0001 << fill_vpn[1:0];
    always_comb f_aligned  = (fill_ppn[1:0] == fill_vpn[1:0]);

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        ctlb_cmp #(
            .VPN_W (VPN_W),
            .PPN_W (PPN_W),
            .ATTR_W(ATTR_W)
        ) u_cmp (
            .e_valid (ent_valid[g]),
            .e_vtag  (ent_vtag[g]),
            .e_ptag  (ent_ptag[g]),
            .e_attr  (ent_attr[g]),
            .e_mask  (ent_mask[g]),
            .e_solo  (ent_solo[g]),
            .lk_vpn  (lk_vpn),
            .f_vpn   (fill_vpn),
            .f_ppn   (fill_ppn),
            .f_attr  (fill_attr),
            .lk_hit  (lk_hit_vec[g]),
            .f_cover (f_cover_vec[g]),
            .f_compat(f_compat_vec[g])
        );
    end

    ctlb_fill_ctl #(
        .ENTRIES(ENTRIES),
        .IDX_W  (IDX_W)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_valid(fill_valid),
        .inv_all   (inv_all),
        .compat    (f_compat_vec),
        .act       (act),
        .tgt_idx   (tgt_idx),
        .ptr       (ptr)
    );

    // Per-entry state update: invalidate, allocate, merge or drop a re-mapped slot.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic [3:0] mask_drop;
        always_comb mask_drop = ent_mask[g] & ~f_slot;

        // Entry register update.
        always_ff @(posedge clk) begin
            if (!rst_n || inv_all) begin
                ent_valid[g] <= 1'b0;
                ent_mask[g]  <= '0;
            end else if (fill_alloc && (ptr == IDX_W'(g))) begin
                ent_valid[g]  <= 1'b1;
                ent_vtag[g]   <= fill_vpn[VPN_W-1:2];
                ent_ptag[g]   <= fill_ppn[PPN_W-1:2];
                ent_attr[g]   <= fill_attr;
                ent_mask[g]   <= f_slot;
                ent_solo[g]   <= !f_aligned;
                ent_sololo[g] <= fill_ppn[1:0];
            end else if ((act == FA_MERGE) && (tgt_idx == IDX_W'(g))) begin
                ent_mask[g] <= ent_mask[g] | f_slot;
            end else if ((act != FA_NONE) && f_cover_vec[g]) begin
                ent_mask[g] <= mask_drop;
                if (mask_drop == 4'b0000) begin
                    ent_valid[g] <= 1'b0;
                end
            end
        end
    end

    // Select the matching entry and form the translated frame.
    logic               sel_hit;
    logic [PPN_W-1:0]   sel_ppn;
    logic [ATTR_W-1:0]  sel_attr;
    logic               sel_big;
    always_comb begin
        sel_hit  = 1'b0;
        sel_ppn  = '0;
        sel_attr = '0;
        sel_big  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit_vec[i] && !sel_hit) begin
                sel_hit  = 1'b1;
                sel_attr = ent_attr[i];
                sel_ppn  = {ent_ptag[i], ent_solo[i] ? ent_sololo[i] : lk_vpn[1:0]};
                sel_big  = !ent_solo[i] && (ent_mask[i] == 4'b1111);
            end
        end
    end

    // Register the lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_big   <= 1'b0;
            rsp_paddr <= '0;
            rsp_attr  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && sel_hit;
            rsp_big   <= lk_valid && sel_hit && sel_big;
            rsp_paddr <= {sel_ppn, lk_vaddr[PG_SHIFT-1:0]};
            rsp_attr  <= sel_attr;
        end
    end
endmodule

// File: rtl/ctlb_chk.sv
// Property checker for ctlb_top, attached by bind. It observes ports and the
// entry valid vector, lookup match vector and victim pointer.
module ctlb_chk #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               inv_all,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               rsp_big,
    input logic [ENTRIES-1:0] ent_valid,
    input logic [ENTRIES-1:0] lk_hit_vec,
    input logic               fill_alloc,
    input logic [IDX_W-1:0]   ptr
);
    logic [IDX_W-1:0] ptr_next_exp;
    // Expected pointer after one allocation.
    always_comb ptr_next_exp = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;

    p_rsp_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    p_rsp_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    p_inv_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (ent_valid == '0));
    p_big_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_big |-> rsp_hit);
    p_miss_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> !rsp_big);
    p_single_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_alloc && !inv_all) |=> (ptr == $past(ptr_next_exp)));
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_alloc && !inv_all) |=> $stable(ptr));
endmodule

bind ctlb_top ctlb_chk #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .inv_all   (inv_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_big   (rsp_big),
    .ent_valid (ent_valid),
    .lk_hit_vec(lk_hit_vec),
    .fill_alloc(fill_alloc),
    .ptr       (ptr)
);

// File: tb/sim_ctlb_top.sv
// Directed bench for ctlb_top: one task per scenario, each checking its results.
module sim_ctlb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 32;
    localparam int PA_W = 32;
    localparam int ATTR_W = 4;
    localparam int ENTRIES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic rsp_valid, rsp_hit, rsp_big;
    logic [PA_W-1:0] rsp_paddr;
    logic [ATTR_W-1:0] rsp_attr;
    logic fill_valid = 1'b0;
    logic [VA_W-13:0] fill_vpn = '0;
    logic [PA_W-13:0] fill_ppn = '0;
    logic [ATTR_W-1:0] fill_attr = '0;
    logic inv_all = 1'b0;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctlb_top #(.VA_W(VA_W), .PA_W(PA_W), .ATTR_W(ATTR_W), .ENTRIES(ENTRIES)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_big(rsp_big),
        .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_attr(fill_attr),
        .inv_all(inv_all)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic fill(input int vpn, input int ppn, input int attr);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_vpn = vpn[VA_W-13:0];
        fill_ppn = ppn[PA_W-13:0];
        fill_attr = attr[ATTR_W-1:0];
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic invalidate();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    // Lookup one page and compare; the response is registered at the next edge.
    task automatic look(input string req, input int vpn, input int off, input bit hit,
                        input int ppn, input int attr, input bit big);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_vaddr = {vpn[VA_W-13:0], off[11:0]};
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({req, " hit"}, 64'(rsp_hit), 64'(hit));
        check({req, " big"}, 64'(rsp_big), 64'(big));
        if (hit) begin
            check({req, " paddr"}, 64'(rsp_paddr), 64'({ppn[PA_W-13:0], off[11:0]}));
            check({req, " attr"}, 64'(rsp_attr), 64'(attr[ATTR_W-1:0]));
        end
    endtask

    task automatic t_reset();
        check("R1 reset rsp_hit", 64'(rsp_hit), 64'd0);
        check("R7 reset rsp_valid", 64'(rsp_valid), 64'd0);
        look("R1 empty", 'h1, 'h0, 1'b0, 0, 0, 1'b0);
        @(negedge clk);
        check("R7 idle rsp_valid", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_single();
        invalidate();
        fill('h10, 'h230, 5);
        look("R2 single", 'h10, 'hABC, 1'b1, 'h230, 5, 1'b0);
        look("R2 other page", 'h11, 'h0, 1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_merge_and_evict();
        invalidate();
        fill('h40, 'h80, 3);
        fill('h41, 'h81, 3);
        fill('h43, 'h83, 3);
        look("R3 partial", 'h41, 'h4, 1'b1, 'h81, 3, 1'b0);
        fill('h42, 'h82, 3);
        look("R3 full slot2", 'h42, 'h10, 1'b1, 'h82, 3, 1'b1);
        look("R3 full slot0", 'h40, 'hFFF, 1'b1, 'h80, 3, 1'b1);
        fill('h100, 'h500, 1);
        fill('h200, 'h600, 1);
        fill('h300, 'h700, 1);
        look("R3 reach kept", 'h43, 'h8, 1'b1, 'h83, 3, 1'b1);
        fill('h400, 'h800, 2);
        look("R8 oldest evicted", 'h43, 'h8, 1'b0, 0, 0, 1'b0);
        look("R8 second kept", 'h100, 'h8, 1'b1, 'h500, 1, 1'b0);
        look("R8 new entry", 'h400, 'h8, 1'b1, 'h800, 2, 1'b0);
    endtask

    task automatic t_noncontig();
        invalidate();
        fill('h40, 'h80, 3);
        fill('h41, 'h95, 3);
        fill('h42, 'h82, 3);
        fill('h43, 'h83, 3);
        look("R4 stray frame", 'h41, 'h0, 1'b1, 'h95, 3, 1'b0);
        look("R4 group kept", 'h42, 'h0, 1'b1, 'h82, 3, 1'b0);
        fill('h41, 'h81, 3);
        look("R10 remap completes", 'h41, 'h20, 1'b1, 'h81, 3, 1'b1);
    endtask

    task automatic t_attr();
        invalidate();
        fill('h40, 'h80, 3);
        fill('h41, 'h81, 3);
        fill('h42, 'h82, 7);
        fill('h43, 'h83, 3);
        look("R5 odd attr", 'h42, 'h0, 1'b1, 'h82, 7, 1'b0);
        look("R5 rest", 'h43, 'h0, 1'b1, 'h83, 3, 1'b0);
    endtask

    task automatic t_misalign();
        invalidate();
        fill('h40, 'h81, 3);
        fill('h41, 'h81, 3);
        fill('h42, 'h82, 3);
        fill('h43, 'h83, 3);
        look("R6 lone page", 'h40, 'h0, 1'b1, 'h81, 3, 1'b0);
        look("R6 partial group", 'h43, 'h0, 1'b1, 'h83, 3, 1'b0);
        fill('h40, 'h80, 3);
        look("R10 lone replaced", 'h40, 'h0, 1'b1, 'h80, 3, 1'b1);
    endtask

    task automatic t_remap();
        invalidate();
        fill('h40, 'h80, 3);
        fill('h40, 'h90, 3);
        look("R10 newest wins", 'h40, 'h4, 1'b1, 'h90, 3, 1'b0);
    endtask

    task automatic t_invalidate();
        fill('h10, 'h230, 5);
        look("R9 before", 'h10, 'h0, 1'b1, 'h230, 5, 1'b0);
        invalidate();
        look("R9 after", 'h10, 'h0, 1'b0, 0, 0, 1'b0);
        look("R9 after other", 'h40, 'h0, 1'b0, 0, 0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_merge_and_evict();
        t_noncontig();
        t_attr();
        t_misalign();
        t_remap();
        t_invalidate();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule